// File: doc/BRIEF.md
# MMIO Window to Partition Decoder

This block sits on the outbound path of a PCIe host bridge. It takes a CPU-side MMIO address and checks it against two kinds of programmable windows. The first kind is one narrow window that produces 32-bit bus addresses. The second kind is a set of wide windows. When the address falls inside a window, the block returns the bus-side address and the number of the isolation partition that owns that address. Ownership is decided by address segmentation. Each window is split into 256 equal segments:

- In the narrow window, a segment picks a partition through a programmable lookup table.
- In a wide window, the segment index is itself the partition number. A wide window can instead hand one fixed number to its whole range.

Configuration is written through a single write port. Requests are decoded with a fixed latency of one clock. When several windows cover an address, a fixed priority picks one. An address that no window covers is flagged as a miss.

Top module: `mwd_decoder`

## Requirements
- R1: `rsp_valid` is high exactly one clock after a cycle with `req_valid` high, and is low in every other cycle. All response outputs are 0 while `rst` is high and in the first cycle after it.
- R2: A window takes part in decoding only if all of the following hold:
  - its enable bit is set;
  - its size is a power of two;
  - its base is a multiple of its size;
  - its size is in range: 256 bytes to 4 GB for the narrow window, at least 256 MB for a wide window.
  A window that breaks any of these never produces a hit.
- R3: On a narrow-window hit, `rsp_addr` is formed from two parts:
  - the bits at and above log2(size) come from the replacement register;
  - the bits below log2(size) are the request offset inside the window.
- R4: On a narrow-window hit, `rsp_pe` is the table entry addressed by the segment index. The segment index is (address − base) >> (log2(size) − 8).
- R5: On a wide-window hit, `rsp_addr` equals the request address unchanged.
- R6: A wide window with the segment-mode bit clear returns its programmed partition number for every address in its range.
- R7: A wide window with the segment-mode bit set returns the segment index, computed as in R4 and zero-extended, as `rsp_pe`.
- R8: If several windows hit, the lowest-numbered wide window wins. The narrow window wins only when no wide window hits. `rsp_src` gives the winner: a wide window reports its own index, and the narrow window reports the value 16.
- R9: A request that hits no window returns `rsp_miss`=1 and `rsp_hit`=0, with `rsp_pe`, `rsp_addr` and `rsp_src` all 0.
- R10: A configuration write in the same cycle as a request does not affect that request. It applies to requests from the next cycle on.
- R11: `cfg_kind` selects what a write updates:
  - 0: narrow base.
  - 1: narrow size.
  - 2: narrow replacement value.
  - 3: narrow enable, taken from bit 0.
  - 4: table entry `cfg_idx`, taken from bits [7:0].
  - 5: base of wide window `cfg_idx`.
  - 6: size of wide window `cfg_idx`.
  - 7: control of wide window `cfg_idx`. Bit 0 is enable, bit 1 is segment mode, and bits [9:2] are the partition number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Register kind selector (R11) |
| cfg_idx | input | 8 | Table entry or wide window index |
| cfg_wdata | input | 48 | Write data |
| req_valid | input | 1 | Request valid |
| req_addr | input | 48 | CPU-side address |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_hit | output | 1 | Address hit a window |
| rsp_miss | output | 1 | Address hit no window |
| rsp_addr | output | 48 | Bus-side address |
| rsp_pe | output | 8 | Owning partition number |
| rsp_src | output | 5 | Winning window (0-15 wide, 16 narrow) |

## Verification
Two functions can land in the same cycle:

- **A write and a decode.** A wide window's control register is cleared at the same clock edge as a request into that window. The response is judged against the configuration that was in force before the edge. A follow-up request must then miss.
- **A narrow lookup and a wide hit.** Several windows are stacked on one address: two wide windows over a third, and a wide window over the narrow window's lower segments. The winning index and partition are compared with the priority rule. Addresses just outside the overlap confirm that the lower-priority window still answers there.

// File: rtl/mwd_pkg.sv
package mwd_pkg;

  // Configuration write selector values
  typedef enum logic [2:0] {
    CFG_N_BASE  = 3'd0,
    CFG_N_SIZE  = 3'd1,
    CFG_N_REPL  = 3'd2,
    CFG_N_CTRL  = 3'd3,
    CFG_TABLE   = 3'd4,
    CFG_W_BASE  = 3'd5,
    CFG_W_SIZE  = 3'd6,
    CFG_W_CTRL  = 3'd7
  } cfg_kind_e;

  // Bit positions inside a wide window control word
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_SEG_BIT = 1;
  localparam int CTRL_PE_LSB  = 2;

endpackage

// File: rtl/mwd_cfg.sv
module mwd_cfg
  import mwd_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int PE_W   = 8,
  parameter int SEG_W  = 8,
  parameter int N_WIDE = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        kind,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] n_base,
  output logic [ADDR_W-1:0] n_size,
  output logic [ADDR_W-1:0] n_repl,
  output logic              n_en,
  output logic [ADDR_W-1:0] w_base [N_WIDE],
  output logic [ADDR_W-1:0] w_size [N_WIDE],
  output logic              w_en   [N_WIDE],
  output logic              w_segm [N_WIDE],
  output logic [PE_W-1:0]   w_pe   [N_WIDE],
  input  logic [SEG_W-1:0]  tbl_raddr,
  output logic [PE_W-1:0]   tbl_rdata
);

  localparam int WIDX_W  = (N_WIDE > 1) ? $clog2(N_WIDE) : 1;
  localparam int N_ENTRY = 1 << SEG_W;

  logic [PE_W-1:0] seg_tbl [N_ENTRY];
  logic            wide_ok;
  logic [WIDX_W-1:0] wsel;

  assign wide_ok = (int'(idx) < N_WIDE);
  assign wsel    = idx[WIDX_W-1:0];

  // Window registers, reset to disabled
  always_ff @(posedge clk) begin
    if (rst) begin
      n_base <= '0;
      n_size <= '0;
      n_repl <= '0;
      n_en   <= 1'b0;
      for (int i = 0; i < N_WIDE; i++) begin
        w_base[i] <= '0;
        w_size[i] <= '0;
        w_en[i]   <= 1'b0;
        w_segm[i] <= 1'b0;
        w_pe[i]   <= '0;
      end
    end else if (we) begin
      case (kind)
        CFG_N_BASE: n_base <= wdata;
        CFG_N_SIZE: n_size <= wdata;
        CFG_N_REPL: n_repl <= wdata;
        CFG_N_CTRL: n_en   <= wdata[CTRL_EN_BIT];
        CFG_W_BASE: if (wide_ok) w_base[wsel] <= wdata;
        CFG_W_SIZE: if (wide_ok) w_size[wsel] <= wdata;
        CFG_W_CTRL: if (wide_ok) begin
          w_en[wsel]   <= wdata[CTRL_EN_BIT];
          w_segm[wsel] <= wdata[CTRL_SEG_BIT];
          w_pe[wsel]   <= wdata[CTRL_PE_LSB +: PE_W];
        end
        default: ;
      endcase
    end
  end

  // Segment-to-partition table: no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (we && kind == CFG_TABLE)
      seg_tbl[idx[SEG_W-1:0]] <= wdata[PE_W-1:0];
  end

  assign tbl_rdata = seg_tbl[tbl_raddr];

endmodule

// File: rtl/mwd_match.sv
module mwd_match #(
  parameter int ADDR_W = 48,
  parameter int SEG_W  = 8,
  parameter int MIN_LG = 28,
  parameter int MAX_LG = 47
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] size,
  input  logic              en,
  output logic              hit,
  output logic [SEG_W-1:0]  seg
);

  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] offset;
  logic pow2, aligned, big_enough, small_enough, usable;

  assign mask         = size - 1'b1;
  assign pow2         = (size != '0) && ((size & mask) == '0);
  assign aligned      = (base & mask) == '0;
  assign big_enough   = |(size >> MIN_LG);
  assign small_enough = (size >> MAX_LG) <= ADDR_W'(1);
  assign usable       = en && pow2 && aligned && big_enough && small_enough;
  assign hit          = usable && ((addr & ~mask) == base);
  assign offset       = addr & mask;

  // Segment index: the SEG_W offset bits just below the size bit
  always_comb begin
    seg = '0;
    for (int k = SEG_W; k < ADDR_W; k++) begin
      if (size[k]) seg = offset[k-1 -: SEG_W];
    end
  end

endmodule

// File: rtl/mwd_resolve.sv
module mwd_resolve #(
  parameter int ADDR_W = 48,
  parameter int PE_W   = 8,
  parameter int SEG_W  = 8,
  parameter int N_WIDE = 16,
  parameter int SRC_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [N_WIDE-1:0] w_hit,
  input  logic [SEG_W-1:0]  w_seg  [N_WIDE],
  input  logic              w_segm [N_WIDE],
  input  logic [PE_W-1:0]   w_pe   [N_WIDE],
  input  logic              n_hit,
  input  logic [ADDR_W-1:0] n_size,
  input  logic [ADDR_W-1:0] n_repl,
  input  logic [PE_W-1:0]   tbl_pe,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [PE_W-1:0]   rsp_pe,
  output logic [SRC_W-1:0]  rsp_src
);

  logic [ADDR_W-1:0] n_mask;
  logic              sel_hit;
  logic [SRC_W-1:0]  sel_src;
  logic [PE_W-1:0]   sel_pe;
  logic [ADDR_W-1:0] sel_addr;
  logic              take;

  assign n_mask = n_size - 1'b1;

  // Narrow window first, then wide windows from highest to lowest index
  // so that the lowest hitting wide window overrides everything.
  always_comb begin
    sel_hit  = 1'b0;
    sel_src  = '0;
    sel_pe   = '0;
    sel_addr = '0;
    if (n_hit) begin
      sel_hit  = 1'b1;
      sel_src  = SRC_W'(N_WIDE);
      sel_pe   = tbl_pe;
      sel_addr = (n_repl & ~n_mask) | (req_addr & n_mask);
    end
    for (int i = N_WIDE - 1; i >= 0; i--) begin
      if (w_hit[i]) begin
        sel_hit  = 1'b1;
        sel_src  = SRC_W'(i);
        sel_pe   = w_segm[i] ? PE_W'(w_seg[i]) : w_pe[i];
        sel_addr = req_addr;
      end
    end
  end

  assign take = req_valid && sel_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_addr  <= '0;
      rsp_pe    <= '0;
      rsp_src   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= take;
      rsp_miss  <= req_valid && !sel_hit;
      rsp_addr  <= take ? sel_addr : '0;
      rsp_pe    <= take ? sel_pe   : '0;
      rsp_src   <= take ? sel_src  : '0;
    end
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst) req_valid |=> rsp_valid); // R1
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !rsp_valid); // R1
  AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> (rsp_hit != rsp_miss)); // R9
  AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (rst) rsp_miss |-> (rsp_pe == '0 && rsp_addr == '0 && rsp_src == '0)); // R9
  AST_WIDE_PASSTHRU: assert property (@(posedge clk) disable iff (rst) (rsp_hit && rsp_src != SRC_W'(N_WIDE)) |-> rsp_addr == $past(req_addr)); // R5

endmodule

// File: rtl/mwd_decoder.sv
module mwd_decoder #(
  parameter int ADDR_W        = 48,
  parameter int PE_W          = 8,
  parameter int SEG_W         = 8,
  parameter int N_WIDE        = 16,
  parameter int WIDE_MIN_LG   = 28,
  parameter int NARROW_MAX_LG = 32,
  parameter int IDX_W         = 8,
  parameter int SRC_W         = $clog2(N_WIDE + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_kind,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [PE_W-1:0]   rsp_pe,
  output logic [SRC_W-1:0]  rsp_src
);

  localparam int NARROW_MIN_LG = SEG_W;
  localparam int WIDE_MAX_LG   = ADDR_W - 1;

  logic [ADDR_W-1:0] n_base, n_size, n_repl;
  logic              n_en;
  logic [ADDR_W-1:0] w_base [N_WIDE];
  logic [ADDR_W-1:0] w_size [N_WIDE];
  logic              w_en   [N_WIDE];
  logic              w_segm [N_WIDE];
  logic [PE_W-1:0]   w_pe   [N_WIDE];
  logic [N_WIDE-1:0] w_hit;
  logic [SEG_W-1:0]  w_seg  [N_WIDE];
  logic              n_hit;
  logic [SEG_W-1:0]  n_seg;
  logic [PE_W-1:0]   tbl_pe;

  mwd_cfg #(
    .ADDR_W(ADDR_W), .PE_W(PE_W), .SEG_W(SEG_W),
    .N_WIDE(N_WIDE), .IDX_W(IDX_W)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .kind     (cfg_kind),
    .idx      (cfg_idx),
    .wdata    (cfg_wdata),
    .n_base   (n_base),
    .n_size   (n_size),
    .n_repl   (n_repl),
    .n_en     (n_en),
    .w_base   (w_base),
    .w_size   (w_size),
    .w_en     (w_en),
    .w_segm   (w_segm),
    .w_pe     (w_pe),
    .tbl_raddr(n_seg),
    .tbl_rdata(tbl_pe)
  );

  mwd_match #(
    .ADDR_W(ADDR_W), .SEG_W(SEG_W),
    .MIN_LG(NARROW_MIN_LG), .MAX_LG(NARROW_MAX_LG)
  ) u_narrow (
    .addr(req_addr),
    .base(n_base),
    .size(n_size),
    .en  (n_en),
    .hit (n_hit),
    .seg (n_seg)
  );

  for (genvar g = 0; g < N_WIDE; g++) begin : g_wide
    mwd_match #(
      .ADDR_W(ADDR_W), .SEG_W(SEG_W),
      .MIN_LG(WIDE_MIN_LG), .MAX_LG(WIDE_MAX_LG)
    ) u_wide (
      .addr(req_addr),
      .base(w_base[g]),
      .size(w_size[g]),
      .en  (w_en[g]),
      .hit (w_hit[g]),
      .seg (w_seg[g])
    );
  end

  mwd_resolve #(
    .ADDR_W(ADDR_W), .PE_W(PE_W), .SEG_W(SEG_W),
    .N_WIDE(N_WIDE), .SRC_W(SRC_W)
  ) u_resolve (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .w_hit    (w_hit),
    .w_seg    (w_seg),
    .w_segm   (w_segm),
    .w_pe     (w_pe),
    .n_hit    (n_hit),
    .n_size   (n_size),
    .n_repl   (n_repl),
    .tbl_pe   (tbl_pe),
    .rsp_valid(rsp_valid),
    .rsp_hit  (rsp_hit),
    .rsp_miss (rsp_miss),
    .rsp_addr (rsp_addr),
    .rsp_pe   (rsp_pe),
    .rsp_src  (rsp_src)
  );

endmodule

// File: tb/mwd_decoder_test.sv
`timescale 1ns/1ps
module mwd_decoder_test;

  localparam int AW = 48;
  localparam logic [AW-1:0] NB = 48'h3_0000_0000;
  localparam logic [AW-1:0] NS = 48'h0_8000_0000;
  localparam logic [AW-1:0] NR = 48'h0_8000_0000;
  localparam logic [AW-1:0] WB2 = 48'h10_0000_0000;
  localparam logic [AW-1:0] WS2 = 48'h10_0000_0000;
  localparam logic [AW-1:0] S256M = 48'h0_1000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_kind = '0;
  logic [7:0]    cfg_idx = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid, rsp_hit, rsp_miss;
  logic [AW-1:0] rsp_addr;
  logic [7:0]    rsp_pe;
  logic [4:0]    rsp_src;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic          g_v, g_h, g_m;
  logic [AW-1:0] g_a;
  logic [7:0]    g_pe;
  logic [4:0]    g_s;

  mwd_decoder uut (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_addr(rsp_addr), .rsp_pe(rsp_pe), .rsp_src(rsp_src)
  );

  function automatic logic [7:0] tv(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  // R11: control word bit 0 enable, bit 1 segment mode, bits [9:2] partition
  function automatic logic [AW-1:0] ctrl(bit en, bit segm, logic [7:0] pe);
    return AW'({pe, segm, en});
  endfunction

  task automatic wr(input logic [2:0] k, input int ix, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = k; cfg_idx = 8'(ix); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic grab();
    g_v = rsp_valid; g_h = rsp_hit; g_m = rsp_miss;
    g_a = rsp_addr; g_pe = rsp_pe; g_s = rsp_src;
  endtask

  task automatic judge(input string tag, input bit eh, input logic [7:0] epe,
                       input logic [AW-1:0] ea, input int es);
    n_chk++;
    if (!(g_v === 1'b1 && g_h === eh && g_m === !eh && g_pe === epe &&
          g_a === ea && g_s === 5'(es))) begin
      n_fail++;
      $display("FAIL %s: got v=%0d hit=%0d miss=%0d pe=%h addr=%h src=%0d expected v=1 hit=%0d pe=%h addr=%h src=%0d",
               tag, g_v, g_h, g_m, g_pe, g_a, g_s, eh, epe, ea, es);
    end
  endtask

  task automatic probe(input string tag, input logic [AW-1:0] a, input bit eh,
                       input logic [7:0] epe, input logic [AW-1:0] ea, input int es);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    grab();
    judge(tag, eh, epe, ea, es);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got no end, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_miss !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got v=%0d h=%0d m=%0d expected 0 0 0", rsp_valid, rsp_hit, rsp_miss);
    end
    rst = 1'b0;

    // R9: nothing programmed, everything misses
    probe("R9 unprogrammed", 48'h3_0000_0123, 1'b0, 8'h0, '0, 0);

    // R11: table entries through kind 4, narrow window through kinds 0..3
    for (int i = 0; i < 256; i++) wr(3'd4, i, AW'(tv(i)));
    wr(3'd0, 0, NB);
    wr(3'd1, 0, NS);
    wr(3'd2, 0, NR);
    wr(3'd3, 0, AW'(1));

    // R3 R4: sweep every narrow segment (8 MB each)
    for (int i = 0; i < 256; i++) begin
      a = NB + (AW'(i) << 23) + AW'(i * 13);
      probe("R3 R4 R11 narrow sweep", a, 1'b1, tv(i), NR | ((AW'(i) << 23) + AW'(i * 13)), 16);
    end

    // R1: idle cycle after a response
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 idle: got v=%0d expected 0", rsp_valid);
    end

    // R5 R7: wide window 2, segmented, 64 GB
    wr(3'd5, 2, WB2);
    wr(3'd6, 2, WS2);
    wr(3'd7, 2, ctrl(1'b1, 1'b1, 8'h00));
    for (int i = 0; i < 256; i++) begin
      a = WB2 + (AW'(i) << 28) + 48'h123_4567;
      probe("R5 R7 wide segmented sweep", a, 1'b1, 8'(i), a, 2);
    end

    // R6: wide window 5, unsegmented, minimum size
    wr(3'd5, 5, 48'h20_0000_0000);
    wr(3'd6, 5, S256M);
    wr(3'd7, 5, ctrl(1'b1, 1'b0, 8'h5A));
    probe("R6 first byte", 48'h20_0000_0000, 1'b1, 8'h5A, 48'h20_0000_0000, 5);
    probe("R6 mid", 48'h20_0765_4321, 1'b1, 8'h5A, 48'h20_0765_4321, 5);
    probe("R6 last byte", 48'h20_0FFF_FFFF, 1'b1, 8'h5A, 48'h20_0FFF_FFFF, 5);
    probe("R6 R9 one past end", 48'h20_1000_0000, 1'b0, 8'h0, '0, 0);

    // R8: overlaps among wide windows
    wr(3'd5, 3, WB2);
    wr(3'd6, 3, S256M);
    wr(3'd7, 3, ctrl(1'b1, 1'b0, 8'h33));
    probe("R8 window 2 beats 3", WB2 + 48'h40, 1'b1, 8'h00, WB2 + 48'h40, 2);
    wr(3'd5, 1, WB2);
    wr(3'd6, 1, S256M);
    wr(3'd7, 1, ctrl(1'b1, 1'b0, 8'h11));
    probe("R8 window 1 beats 2 and 3", WB2 + 48'h40, 1'b1, 8'h11, WB2 + 48'h40, 1);
    probe("R8 outside overlap", WB2 + S256M, 1'b1, 8'h01, WB2 + S256M, 2);

    // R8: wide window over the narrow window
    wr(3'd5, 7, NB);
    wr(3'd6, 7, S256M);
    wr(3'd7, 7, ctrl(1'b1, 1'b0, 8'h77));
    probe("R8 wide beats narrow", NB + 48'h40, 1'b1, 8'h77, NB + 48'h40, 7);
    probe("R8 narrow outside wide", NB + S256M, 1'b1, tv(32), NR | S256M, 16);

    // R2: malformed wide windows are disabled
    wr(3'd5, 9, 48'h30_0000_0000);
    wr(3'd6, 9, 48'h0_3000_0000);
    wr(3'd7, 9, ctrl(1'b1, 1'b0, 8'h99));
    probe("R2 size not power of two", 48'h30_0000_0000, 1'b0, 8'h0, '0, 0);
    wr(3'd5, 10, 48'h31_0800_0000);
    wr(3'd6, 10, S256M);
    wr(3'd7, 10, ctrl(1'b1, 1'b0, 8'hAA));
    probe("R2 misaligned base", 48'h31_0800_0000, 1'b0, 8'h0, '0, 0);
    wr(3'd5, 11, 48'h32_0000_0000);
    wr(3'd6, 11, 48'h0_0800_0000);
    wr(3'd7, 11, ctrl(1'b1, 1'b0, 8'hBB));
    probe("R2 wide below 256MB", 48'h32_0000_0000, 1'b0, 8'h0, '0, 0);

    // R2: narrow window above 4 GB disabled, exactly 4 GB accepted (R3)
    wr(3'd0, 0, 48'h4_0000_0000);
    wr(3'd1, 0, 48'h2_0000_0000);
    probe("R2 narrow 8GB", 48'h4_0000_0100, 1'b0, 8'h0, '0, 0);
    wr(3'd1, 0, 48'h1_0000_0000);
    probe("R3 R4 narrow 4GB", 48'h4_0000_0100, 1'b1, tv(0), 48'h0_0000_0100, 16);
    probe("R3 R4 narrow 4GB top seg", 48'h4_FF00_0010, 1'b1, tv(255), 48'h0_FF00_0010, 16);
    wr(3'd3, 0, AW'(0));
    probe("R2 narrow disabled", 48'h4_0000_0100, 1'b0, 8'h0, '0, 0);

    // R10: write disabling window 5 in the same cycle as a request into it
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = 3'd7; cfg_idx = 8'd5; cfg_wdata = '0;
    req_valid = 1'b1; req_addr = 48'h20_0000_0010;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    grab();
    judge("R10 same-cycle write uses old config", 1'b1, 8'h5A, 48'h20_0000_0010, 5);
    probe("R10 next request sees write", 48'h20_0000_0010, 1'b0, 8'h0, '0, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule